// File: doc/BRIEF.md
# Packed Logical Right Shifter

This block shifts a 128-bit vector right by a single unsigned count, treating the vector as a set of equal, independent lanes. A two-bit lane selector splits the vector into eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Each lane is shifted on its own: zeros enter from the top, and no bit ever crosses from one lane into the next. Any lane whose count is at least as large as its width is cleared to zero.

The count comes from one of two places. With the source select low, it is the whole lower 64-bit half of a second 128-bit operand, read as one unsigned number and applied to every lane. With the source select high, it is an 8-bit immediate, zero-extended. Both operands are sampled at the same clock edge as the data, so using one register value as both data and count gives the correct result.

A two-state controller sequences the output. In ST_IDLE the result register holds its value and the valid flag is low. Transition T_ISSUE (a strobe in ST_IDLE) moves to ST_SHOW and captures a result. Transition T_CHAIN (a strobe in ST_SHOW) stays in ST_SHOW and captures the next result. Transition T_DRAIN (no strobe in ST_SHOW) returns to ST_IDLE. Transition T_WAIT (no strobe in ST_IDLE) stays in ST_IDLE. The valid flag is high exactly in ST_SHOW.

Top module: `vec_rshift_unit`

## Requirements
- R1: `lane_sel` encodes the lane width as 0 = 16 bits (eight lanes), 1 = 32 bits (four lanes), 2 = 64 bits (two lanes). Each lane is shifted right on its own, zeros enter at its top bit and no bit crosses a lane boundary.
- R2: With `cnt_src` = 0, the count is `cnt_vec[63:0]` as an unsigned 64-bit number, shared by all lanes. `cnt_vec[127:64]` has no effect on the result.
- R3: With `cnt_src` = 1, the count is `imm_cnt` zero-extended, and `cnt_vec` has no effect on the result.
- R4: A lane becomes all zeros when the count is greater than or equal to its width. This includes any register count with a set bit above bit 5.
- R5: A count of zero passes `data_vec` through unchanged for lane codes 0, 1 and 2.
- R6: The data and count operands are sampled at the same edge, so applying one value to both `data_vec` and `cnt_vec` yields the shift of that value by its own low 64 bits.
- R7: `out_valid` is high in the cycle after each cycle with `in_valid` high, and the matching result is on `out_vec` then. `out_valid` is low after a cycle with `in_valid` low. Back-to-back strobes give back-to-back results.
- R8: While `in_valid` is low, `out_vec` keeps its last value.
- R9: Reset (active-low `rst_n`) clears `out_vec` to zero and `out_valid` to 0.
- R10: Lane code 3 is reserved and produces an all-zero result, with `out_valid` still raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that starts one shift |
| data_vec | input | 128 | Vector to be shifted |
| cnt_vec | input | 128 | Count operand; only bits 63:0 are used |
| imm_cnt | input | 8 | Immediate count |
| lane_sel | input | 2 | Lane width code (0:16, 1:32, 2:64, 3:reserved) |
| cnt_src | input | 1 | 0 = count from cnt_vec, 1 = count from imm_cnt |
| out_vec | output | 128 | Registered shifted vector |
| out_valid | output | 1 | High in the cycle after a strobe |

## Verification
The shift is tried with counts just below and exactly at each lane width, with zero, and with huge register counts that have only a high bit set. Together these separate a correct saturation test from a truncated count. Data patterns with every lane's low and high bits set show whether bits leak across lane boundaries. Garbage in the unused half of the count operand, and in the count operand when the immediate source is selected, shows whether the source mux picks the right field. Runs of strobes, with and without gaps, separate back-to-back capture from the hold behaviour. A value used as both data and count, and random operands at every lane code, exercise the general case.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

    localparam int VEC_W = 128;
    localparam int CNT_W = 64;
    localparam int IMM_W = 8;

    typedef enum logic [1:0] {
        LW_16  = 2'd0,
        LW_32  = 2'd1,
        LW_64  = 2'd2,
        LW_RSV = 2'd3
    } lane_sel_e;

    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_IMM = 1'b1
    } cnt_src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ctl_state_e;

    // Mask with the top bit of every lane of width lw set
    function automatic logic [VEC_W-1:0] lane_msb_mask(input int lw);
        logic [VEC_W-1:0] m;
        m = '0;
        for (int b = 0; b < VEC_W; b++) begin
            if ((b % lw) == (lw - 1)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/vrs_count_pick.sv
module vrs_count_pick
    import vrs_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int IW = IMM_W
) (
    input  logic [CW-1:0] reg_cnt,
    input  logic [IW-1:0] imm_cnt,
    input  logic          use_imm,
    output logic [CW-1:0] eff_cnt
);

    localparam int PAD_W = CW - IW;

    always_comb begin
        if (use_imm) eff_cnt = {{PAD_W{1'b0}}, imm_cnt};
        else         eff_cnt = reg_cnt;
    end

endmodule

// File: rtl/vrs_lane_bank.sv
module vrs_lane_bank #(
    parameter int VW = 128,
    parameter int LW = 16,
    parameter int CW = 64
) (
    input  logic [VW-1:0] din,
    input  logic [CW-1:0] cnt,
    output logic [VW-1:0] dout
);

    localparam int LANES = VW / LW;
    localparam int SH_W  = $clog2(LW);

    logic             over;
    logic [SH_W-1:0]  amt;

    // Any count bit at or above log2(width) means count >= width
    assign over = |cnt[CW-1:SH_W];
    assign amt  = cnt[SH_W-1:0];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LW-1:0] lane_in;
        logic [LW-1:0] lane_out;
        assign lane_in  = din[l*LW +: LW];
        assign lane_out = over ? '0 : (lane_in >> amt);
        assign dout[l*LW +: LW] = lane_out;
    end

endmodule

// File: rtl/vec_rshift_unit.sv
module vec_rshift_unit
    import vrs_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int CW = CNT_W,
    parameter int IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [VW-1:0] data_vec,
    input  logic [VW-1:0] cnt_vec,
    input  logic [IW-1:0] imm_cnt,
    input  logic [1:0]    lane_sel,
    input  logic          cnt_src,
    output logic [VW-1:0] out_vec,
    output logic          out_valid
);

    localparam int NBANK = 3;
    localparam logic [VW-1:0] MSB16 = lane_msb_mask(16);

    ctl_state_e    state_q, state_d;
    logic [CW-1:0] eff_cnt;
    logic [VW-1:0] bank_res [NBANK];
    logic [VW-1:0] sel_res;
    logic [VW-1:0] out_q;
    logic          unused_cnt_hi;

    assign unused_cnt_hi = ^cnt_vec[VW-1:CW];

    vrs_count_pick #(.CW(CW), .IW(IW)) i_pick (
        .reg_cnt (cnt_vec[CW-1:0]),
        .imm_cnt (imm_cnt),
        .use_imm (cnt_src == SRC_IMM),
        .eff_cnt (eff_cnt)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        vrs_lane_bank #(.VW(VW), .LW(16 << g), .CW(CW)) i_bank (
            .din  (data_vec),
            .cnt  (eff_cnt),
            .dout (bank_res[g])
        );
    end

    always_comb begin
        unique case (lane_sel_e'(lane_sel))
            LW_16:   sel_res = bank_res[0];
            LW_32:   sel_res = bank_res[1];
            LW_64:   sel_res = bank_res[2];
            default: sel_res = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;   // T_ISSUE / T_WAIT
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;   // T_CHAIN / T_DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)        out_q <= '0;
        else if (in_valid) out_q <= sel_res;
    end

    assign out_vec   = out_q;
    assign out_valid = (state_q == ST_SHOW);

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));

    assert_big_count_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_src == 1'b0 && (|cnt_vec[CW-1:6])) |=> (out_vec == '0));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'd3) |=> (out_vec == '0));

    assert_no_cross_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'd0 && cnt_src == 1'b1 && imm_cnt != '0)
        |=> ((out_vec & MSB16) == '0));

    assert_zero_count_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel != 2'd3 &&
         ((cnt_src == 1'b0 && cnt_vec[CW-1:0] == '0) ||
          (cnt_src == 1'b1 && imm_cnt == '0)))
        |=> (out_vec == $past(data_vec)));

endmodule

// File: tb/test_vec_rshift_unit.sv
module test_vec_rshift_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] data_vec = '0;
    logic [127:0] cnt_vec = '0;
    logic [7:0]   imm_cnt = '0;
    logic [1:0]   lane_sel = '0;
    logic         cnt_src = 1'b0;
    logic [127:0] out_vec;
    logic         out_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [127:0] exp_q[$];
    string        tag_q[$];
    logic [127:0] last_exp = '0;

    always #10 clk = ~clk;   // 50 MHz

    vec_rshift_unit i_vec_rshift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .data_vec(data_vec), .cnt_vec(cnt_vec), .imm_cnt(imm_cnt),
        .lane_sel(lane_sel), .cnt_src(cnt_src),
        .out_vec(out_vec), .out_valid(out_valid)
    );

    function automatic logic [127:0] model(logic [127:0] d, logic [127:0] c,
                                           logic [7:0] im, logic [1:0] sel, logic src);
        logic [127:0] r;
        logic [63:0]  n;
        int w;
        r = '0;
        n = src ? {56'd0, im} : c[63:0];
        case (sel)
            2'd0: w = 16;
            2'd1: w = 32;
            2'd2: w = 64;
            default: w = 0;
        endcase
        if (w == 0) return r;
        for (int b = 0; b < 128; b++) begin
            int off;
            off = b % w;
            if (n < 64'(w) && (off + int'(n)) < w)
                r[b] = d[b - off + off + int'(n)];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(string tag, logic [127:0] d, logic [127:0] c,
                      logic [7:0] im, logic [1:0] sel, logic src);
        @(negedge clk);
        data_vec = d; cnt_vec = c; imm_cnt = im; lane_sel = sel; cnt_src = src;
        in_valid = 1'b1;
        last_exp = model(d, c, im, sel, src);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        data_vec = {4{32'hDEAD_BEEF}};
        cnt_vec = '0;
        imm_cnt = '0;
    endtask

    // Monitor: pop expected results as the design produces them
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 actual=out_valid_high expected=no_result");
            end else begin
                logic [127:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, out_vec, e);
            end
        end
    end

    localparam logic [127:0] PAT_A = 128'hFFFF_8001_1234_ABCD_8000_0001_FFFF_FFFF;
    localparam logic [127:0] PAT_B = 128'h8000_0000_0000_0001_8000_0000_0000_0001;

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset out_vec", out_vec, '0);
        check("R9 reset out_valid", {127'd0, out_valid}, '0);
        @(negedge clk); rst_n = 1'b1;

        // R1: each width, moderate count
        op("R1 w16 cnt4", PAT_A, 128'd4, 8'd0, 2'd0, 1'b0);
        op("R1 w32 cnt4", PAT_A, 128'd4, 8'd0, 2'd1, 1'b0);
        op("R1 w64 cnt4", PAT_A, 128'd4, 8'd0, 2'd2, 1'b0);
        op("R1 w16 cnt1 lanes", PAT_B, 128'd1, 8'd0, 2'd0, 1'b0);
        // R2: upper half of count operand ignored
        op("R2 hi garbage w32", PAT_A, {64'hFFFF_FFFF_FFFF_FFFF, 64'd3}, 8'd0, 2'd1, 1'b0);
        // R3: immediate source, count operand ignored
        op("R3 imm w16", PAT_A, {128{1'b1}}, 8'd7, 2'd0, 1'b1);
        op("R3 imm w64", PAT_B, 128'd2, 8'd63, 2'd2, 1'b1);
        // R4: boundaries
        op("R4 w16 cnt15", PAT_A, 128'd15, 8'd0, 2'd0, 1'b0);
        op("R4 w16 cnt16", PAT_A, 128'd16, 8'd0, 2'd0, 1'b0);
        op("R4 w32 cnt31", PAT_A, 128'd31, 8'd0, 2'd1, 1'b0);
        op("R4 w32 cnt32", PAT_A, 128'd32, 8'd0, 2'd1, 1'b0);
        op("R4 w64 cnt64", PAT_A, 128'd64, 8'd0, 2'd2, 1'b0);
        op("R4 huge count", PAT_A, {64'd0, 64'h0000_0100_0000_0001}, 8'd0, 2'd2, 1'b0);
        op("R4 top bit count", PAT_A, {64'd0, 64'h8000_0000_0000_0000}, 8'd0, 2'd0, 1'b0);
        op("R4 imm 200", PAT_A, '0, 8'd200, 2'd1, 1'b1);
        // R5: zero count
        op("R5 zero reg w16", PAT_A, 128'd0, 8'd9, 2'd0, 1'b0);
        op("R5 zero imm w64", PAT_A, 128'd5, 8'd0, 2'd2, 1'b1);
        // R6: same value as data and count
        op("R6 same operand", 128'h0123_4567_89AB_CDEF_0000_0000_0000_0005,
           128'h0123_4567_89AB_CDEF_0000_0000_0000_0005, 8'd0, 2'd0, 1'b0);
        // R10: reserved lane code
        op("R10 reserved", PAT_A, 128'd1, 8'd0, 2'd3, 1'b0);

        // R7/R8: single strobe then idle; valid drops and value holds
        op("R7 single", PAT_A, 128'd8, 8'd0, 2'd1, 1'b0);
        idle();
        @(negedge clk);
        check("R7 valid low after gap", {127'd0, out_valid}, '0);
        check("R8 hold after gap", out_vec, last_exp);
        @(negedge clk);
        check("R8 hold second cycle", out_vec, last_exp);

        // Random traffic with occasional gaps
        for (int k = 0; k < 200; k++) begin
            logic [127:0] d, c;
            d = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, 32'd0, $urandom % 80};
            op("R1 random", d, c, 8'($urandom % 90), 2'($urandom % 4), 1'($urandom % 2));
            if ((k % 7) == 0) idle();
        end
        idle();
        @(negedge clk);

        // R9: reset mid-run
        op("R7 before reset", PAT_B, 128'd3, 8'd0, 2'd0, 1'b0);
        idle();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset out_vec", out_vec, '0);
        check("R9 mid reset out_valid", {127'd0, out_valid}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 queue drained", 128'(exp_q.size()), '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule